// File: doc/BRIEF.md
# Video Sync Interval Meter

This block times two intervals of a video raster whenever software asks for one. It works in one of two modes. In line mode it counts pulses of a count-enable tick. In frame mode it counts horizontal sync rising edges, so the result is in lines.

When software sets the start bit, the block waits for the first rising edge of the selected sync signal. That edge clears both counters. The first counter closes on the next rising edge of the active-video input. The second counter closes on the next rising edge of the selected sync signal, so it spans one full period. At that point hardware clears the start bit.

Both results are 11 bits wide. Each saturates at 0x7FF. Software reads them through a small byte-wide register port. The active-video input and both sync inputs pass through two-flop synchronizers before their edges are detected.

Top module: `sync_interval_meter`

## Requirements
- R1: After reset, the control/status byte (address 0) reads 0xFC. The first-interval low byte (address 1) reads 0xFF. The second-interval low byte (address 2) reads 0xFF. Read data appears on the clock edge after the address is presented.
- R2: The control/status byte is laid out as {second[10:8], first[10:8], mode, start}, with mode at bit 1 and start at bit 0. Writes to address 0 only reach bits 1:0. Bits 7:2 change only when a measurement completes.
- R3: Mode bit 1 selects line mode and mode bit 0 selects frame mode. A write to the mode bit is ignored while start reads 1.
- R4: Writing 1 to start begins a measurement. Writing 0 to start has no effect. Hardware clears start when the second interval closes, and the stored results do not change while start is 0.
- R5: In line mode, horizontal sync is the selected sync. Each interval's value is the number of cycles with the tick high, counted strictly between the clock cycle of the opening edge and the cycle of its closing edge. With the tick held high, the value is the edge distance in cycles minus one, and with the tick held low it is 0.
- R6: In frame mode, vertical sync is the selected sync. Each counter advances once per horizontal sync rising edge, so the first value is the number of lines before active video and the second is the number of lines in the frame.
- R7: A counter that reaches 0x7FF stays there rather than wrapping.
- R8: If no active-video rising edge arrives before the closing sync edge, the first interval takes its count at that closing edge, and start is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable pulse used in line mode |
| av_i | input | 1 | Active-video input, asynchronous |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control/status, 1 first low, 2 second low) |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |

## Verification
A table of line-mode and frame-mode measurements drives different edge spacings through the same loop. Short spacings and zero-line spacings are tried, along with results above 255 that exercise the high bits in the control/status byte, so a mix-up of fields or modes shows up. Directed runs cover the remaining behaviour:
- a tick held low, which separates tick gating from plain cycle counting;
- a missing active-video edge, which checks that the first count is taken at the close;
- an over-long period that must saturate;
- writes made during a measurement, which must leave the mode and start bits untouched.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} vtm_state_e;
  localparam logic [1:0] ADDR_CSR = 2'd0;
  localparam logic [1:0] ADDR_T1  = 2'd1;
  localparam logic [1:0] ADDR_T2  = 2'd2;
endpackage

// File: rtl/vtm_sync_edge.sv
module vtm_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-1:0], async_i[g]};
    end
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];

    // edge strobes feeding the R5/R6 counting last exactly one cycle
    p_one_cycle_rise_r5: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/vtm_interval_ctr.sv
module vtm_interval_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= SAT;
    else if (clear_i)               cnt <= '0;
    else if (adv_i && cnt != SAT)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        result_o <= SAT;
    else if (cap_i) result_o <= cnt;
  end

  p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == SAT && !clear_i) |=> cnt == SAT);
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> cnt >= $past(cnt));
endmodule

// File: rtl/vtm_ctrl.sv
module vtm_ctrl
  import vtm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csr_wr_i,
  input  logic [1:0] csr_wdata_i,
  input  logic       tick_i,
  input  logic       av_rise_i,
  input  logic       hs_rise_i,
  input  logic       vs_rise_i,
  output logic       hv_o,
  output logic       start_o,
  output logic       clr_o,
  output logic       t1_adv_o,
  output logic       t2_adv_o,
  output logic       t1_cap_o,
  output logic       t2_cap_o
);
  vtm_state_e state;
  logic       t1_live;
  logic       sel_rise;
  logic       adv;

  assign sel_rise = hv_o ? hs_rise_i : vs_rise_i;
  assign adv      = hv_o ? tick_i    : hs_rise_i;
  assign start_o  = (state != ST_IDLE);

  always_comb begin
    clr_o    = (state == ST_ARM) && sel_rise;
    t2_cap_o = (state == ST_RUN) && sel_rise;
    t1_cap_o = (state == ST_RUN) && t1_live && (av_rise_i || sel_rise);
    t1_adv_o = (state == ST_RUN) && t1_live && adv;
    t2_adv_o = (state == ST_RUN) && adv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      t1_live <= 1'b0;
      hv_o    <= 1'b0;
    end else begin
      if (csr_wr_i && state == ST_IDLE) hv_o <= csr_wdata_i[1];
      case (state)
        ST_IDLE: if (csr_wr_i && csr_wdata_i[0]) state <= ST_ARM;
        ST_ARM: if (sel_rise) begin
          state   <= ST_RUN;
          t1_live <= 1'b1;
        end
        ST_RUN: begin
          if (av_rise_i) t1_live <= 1'b0;
          if (sel_rise) begin
            state   <= ST_IDLE;
            t1_live <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_mode_locked_r3: assert property (@(posedge clk) disable iff (rst)
    start_o |=> $stable(hv_o));
  p_hw_clear_r4: assert property (@(posedge clk) disable iff (rst)
    t2_cap_o |=> !start_o);
  p_sw_zero_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (start_o && csr_wr_i && !csr_wdata_i[0] && !t2_cap_o) |=> start_o);
endmodule

// File: rtl/sync_interval_meter.sv
module sync_interval_meter
  import vtm_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              av_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [2:0]       rise;
  logic             hv, start, clr, t1_adv, t2_adv, t1_cap, t2_cap, csr_wr;
  logic [CNT_W-1:0] t1_res, t2_res;
  logic             unused_wdata;

  assign unused_wdata = ^wr_data_i[DATA_W-1:2];
  assign csr_wr       = wr_en_i && (addr_i == ADDR_CSR);

  vtm_sync_edge #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({vsync_i, hsync_i, av_i}),
    .rise_o(rise)
  );

  vtm_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .csr_wr_i(csr_wr), .csr_wdata_i(wr_data_i[1:0]),
    .tick_i(tick_i),
    .av_rise_i(rise[0]), .hs_rise_i(rise[1]), .vs_rise_i(rise[2]),
    .hv_o(hv), .start_o(start), .clr_o(clr),
    .t1_adv_o(t1_adv), .t2_adv_o(t2_adv),
    .t1_cap_o(t1_cap), .t2_cap_o(t2_cap)
  );

  vtm_interval_ctr #(.CNT_W(CNT_W)) u_t1 (
    .clk(clk), .rst(rst), .clear_i(clr), .adv_i(t1_adv),
    .cap_i(t1_cap), .result_o(t1_res)
  );

  vtm_interval_ctr #(.CNT_W(CNT_W)) u_t2 (
    .clk(clk), .rst(rst), .clear_i(clr), .adv_i(t2_adv),
    .cap_i(t2_cap), .result_o(t2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      case (addr_i)
        ADDR_CSR: rd_data_o <= {t2_res[CNT_W-1 -: HI_W], t1_res[CNT_W-1 -: HI_W], hv, start};
        ADDR_T1:  rd_data_o <= t1_res[DATA_W-1:0];
        ADDR_T2:  rd_data_o <= t2_res[DATA_W-1:0];
        default:  rd_data_o <= '0;
      endcase
    end
  end

  p_idle_results_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(t1_res) && $stable(t2_res)));
endmodule

// File: tb/tb_sync_interval_meter.sv
module tb_sync_interval_meter;
  localparam time PERIOD = 10ns;
  localparam int  NVEC   = 7;
  // {line_mode, a, b, expected_first, expected_second}
  localparam logic [44:0] VECS [NVEC] = '{
    {1'b1, 11'd5,   11'd40,   11'd4,   11'd39},
    {1'b1, 11'd3,   11'd10,   11'd2,   11'd9},
    {1'b1, 11'd100, 11'd700,  11'd99,  11'd699},
    {1'b1, 11'd600, 11'd1500, 11'd599, 11'd1499},
    {1'b0, 11'd2,   11'd6,    11'd2,   11'd6},
    {1'b0, 11'd0,   11'd3,    11'd0,   11'd3},
    {1'b0, 11'd9,   11'd12,   11'd9,   11'd12}
  };

  logic clk = 0, rst = 1, tick = 1, av = 0, hs = 0, vs = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sync_interval_meter dut (
    .clk(clk), .rst(rst), .tick_i(tick), .av_i(av), .hsync_i(hs),
    .vsync_i(vs), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = 2'd0; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic check_all(string req, bit mode, logic [10:0] e1, logic [10:0] e2);
    logic [7:0] d;
    rd(2'd0, d); check(req, d, {e2[10:8], e1[10:8], mode, 1'b0});
    rd(2'd1, d); check(req, d, e1[7:0]);
    rd(2'd2, d); check(req, d, e2[7:0]);
  endtask

  task automatic run_line(bit do_wr, int a, int b, bit with_av);
    if (do_wr) wr(8'h03);
    repeat (3) @(negedge clk);
    for (int i = 0; i <= b + 2; i++) begin
      @(negedge clk);
      hs = (i < 2) || (i >= b && i < b + 2);
      av = with_av && (i >= a && i < a + 2);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic run_frame(int a, int b);
    wr(8'h01);
    repeat (3) @(negedge clk);
    for (int i = 0; i <= 4*b + 4; i++) begin
      @(negedge clk);
      vs = (i < 2) || (i >= 4*b + 2 && i < 4*b + 4);
      hs = (i >= 4) && (i < 4*b + 4) && ((i % 4) < 2);
      av = (i == 4*a + 2) || (i == 4*a + 3);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd(2'd0, d); check("R1", d, 8'hFC);
    rd(2'd1, d); check("R1", d, 8'hFF);
    rd(2'd2, d); check("R1", d, 8'hFF);
    // R2 upper control bits are read-only
    wr(8'hFC);
    rd(2'd0, d); check("R2", d, 8'hFC);
    // R3/R4 writes during a measurement
    wr(8'h03);
    rd(2'd0, d); check("R4", d, 8'hFF);
    wr(8'h01);
    rd(2'd0, d); check("R3", d, 8'hFF);
    wr(8'h02);
    rd(2'd0, d); check("R4", d, 8'hFF);
    run_line(0, 5, 20, 1);
    check_all("R3", 1'b1, 11'd4, 11'd19);
    // table of measurements (R5 line, R6 frame)
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v][44]) begin
        run_line(1, int'(VECS[v][43:33]), int'(VECS[v][32:22]), 1);
        check_all("R5", 1'b1, VECS[v][21:11], VECS[v][10:0]);
      end else begin
        run_frame(int'(VECS[v][43:33]), int'(VECS[v][32:22]));
        check_all("R6", 1'b0, VECS[v][21:11], VECS[v][10:0]);
      end
    end
    // R5 tick gating: tick held low counts nothing
    tick = 0;
    run_line(1, 5, 20, 1);
    check_all("R5", 1'b1, 11'd0, 11'd0);
    tick = 1;
    // R8 missing active video
    run_line(1, 5, 30, 0);
    check_all("R8", 1'b1, 11'd29, 11'd29);
    // R7 saturation
    run_line(1, 5, 2200, 0);
    check_all("R7", 1'b1, 11'h7FF, 11'h7FF);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule